// File: doc/BRIEF.md
# Crosspoint Configuration Command Decoder

This block holds the control state of a video routing matrix with 32 sources and 16 destinations. It accepts one 16-bit command word per cycle through a valid/ready port. From those words it keeps, for every destination, a source number, an individual drive enable and a gain choice. It also keeps a clamp enable shared by all inputs, a global enable and a power flag. A broadcast command can point every destination at one source for a time. When broadcast is turned off, the routing that was held before comes back unchanged.

All configuration outputs come straight from flops inside the block. A word accepted on a rising clock edge shows on the outputs right after that edge. The command port never applies back-pressure: `cmd_ready` is always 1, so every cycle with `cmd_valid` high consumes a word. Bits 15:13 of the word hold the opcode.

Top module: `xbar_cfg_ctrl`

## Requirements
- R1: While `rst` is high and after it falls, with no command yet accepted, `drive_en` is all zero, `gain_x2` is all zero, every source select is 0, `clamp_en` is 0 and `standby` is 1.
- R2: Opcode 000 (route): bits 12:8 give a source 0–31 and bits 3:0 a destination 0–15. Only that destination's 5-bit field in `src_sel` changes. The field for destination d sits at bits 5d+4:5d. Several destinations may hold the same source.
- R3: Opcode 001 (enable): bits 9:8 choose bank b, which covers destinations 4b to 4b+3. Word bits 0, 2, 4 and 6 set the individual enables of destinations 4b, 4b+1, 4b+2 and 4b+3. The other banks keep their values.
- R4: Opcode 010 (gain): same bank and bit layout as R3. A bit value of 1 sets `gain_x2` (gain of two) and a value of 0 sets unity gain.
- R5: `drive_en[d]` is 1 only when destination d's individual enable, the global enable and the power bit are all 1.
- R6: Opcode 011 (broadcast): bits 12:8 give a source and bit 0 a flag. While the flag is 1, every destination field of `src_sel` equals that source.
- R7: A broadcast word with bit 0 = 0 makes `src_sel` show again the routing that was held before broadcast began.
- R8: Route words accepted while broadcast is on are dropped. They leave the saved routing unchanged, and this can be seen once broadcast ends.
- R9: Opcode 111 (control): bit 0 sets `clamp_en`, bit 1 sets the global enable and bit 2 sets the power bit. `standby` is the inverse of the power bit.
- R10: Opcodes 100, 101 and 110 change no output.
- R11: A cycle with `cmd_valid` low changes no output, whatever is on `cmd_word`. `cmd_ready` is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command word present |
| cmd_ready | output | 1 | Always 1; the block accepts a word every cycle |
| cmd_word | input | 16 | Command word; opcode in bits 15:13 |
| src_sel | output | 80 | Source number per destination, 5 bits each, destination d at bits 5d+4:5d |
| drive_en | output | 16 | Gated drive enable per destination |
| gain_x2 | output | 16 | 1 selects gain of two, 0 selects unity gain |
| clamp_en | output | 1 | Clamp enable shared by all inputs |
| standby | output | 1 | 1 while the power bit is 0 |

## Verification
The hardest situation to reach from the ports is a saved routing that sits hidden behind an active broadcast while route words try to change it. The dropped words can only be observed after broadcast is cleared. The stimulus first loads a distinct source into every destination and turns broadcast on. It then sends a full set of route words that would overwrite each destination, clears broadcast, and compares every field against the routing from before. A long pseudo-random stream of words with all eight opcodes then mixes broadcast on/off toggles with routes, bank writes and control words, so that these overlaps happen many times.

// File: rtl/xbar_cfg_pkg.sv
package xbar_cfg_pkg;
  localparam logic [2:0] OPC_ROUTE  = 3'b000;
  localparam logic [2:0] OPC_ENABLE = 3'b001;
  localparam logic [2:0] OPC_GAIN   = 3'b010;
  localparam logic [2:0] OPC_BCAST  = 3'b011;
  localparam logic [2:0] OPC_CTRL   = 3'b111;

  // Decoded command, one strobe per accepted opcode
  typedef struct packed {
    logic       route_we;
    logic       en_we;
    logic       gain_we;
    logic       bcast_we;
    logic       ctrl_we;
    logic [4:0] src;
    logic [3:0] dst;
    logic [1:0] bank;
    logic [3:0] lane;
    logic       bc_flag;
    logic [2:0] ctrl;
  } cmd_t;
endpackage

// File: rtl/xbar_cmd_decode.sv
module xbar_cmd_decode
  import xbar_cfg_pkg::*;
(
  input  logic        valid,
  input  logic [15:0] word,
  output cmd_t        cmd
);
  logic [2:0] opc;
  assign opc = word[15:13];

  always_comb begin
    cmd          = '0;
    cmd.route_we = valid && (opc == OPC_ROUTE);
    cmd.en_we    = valid && (opc == OPC_ENABLE);
    cmd.gain_we  = valid && (opc == OPC_GAIN);
    cmd.bcast_we = valid && (opc == OPC_BCAST);
    cmd.ctrl_we  = valid && (opc == OPC_CTRL);
    cmd.src      = word[12:8];
    cmd.dst      = word[3:0];
    cmd.bank     = word[9:8];
    cmd.lane     = {word[6], word[4], word[2], word[0]};
    cmd.bc_flag  = word[0];
    cmd.ctrl     = word[2:0];
  end
endmodule

// File: rtl/xbar_route_map.sv
module xbar_route_map
  import xbar_cfg_pkg::*;
#(
  parameter int N_IN  = 32,
  parameter int N_OUT = 16,
  localparam int SEL_W = $clog2(N_IN)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  cmd_t                   cmd,
  output logic [N_OUT*SEL_W-1:0] src_sel
);
  logic [SEL_W-1:0] map_q [N_OUT];
  logic             bc_on;
  logic [SEL_W-1:0] bc_src;

  always_ff @(posedge clk) begin
    if (rst) begin
      bc_on  <= 1'b0;
      bc_src <= '0;
    end else if (cmd.bcast_we) begin
      bc_on  <= cmd.bc_flag;
      bc_src <= cmd.src[SEL_W-1:0];
    end
  end

  for (genvar i = 0; i < N_OUT; i++) begin : g_dst
    always_ff @(posedge clk) begin
      if (rst)
        map_q[i] <= '0;
      else if (cmd.route_we && !bc_on && cmd.dst == 4'(i))
        map_q[i] <= cmd.src[SEL_W-1:0];
    end

    assign src_sel[i*SEL_W +: SEL_W] = bc_on ? bc_src : map_q[i];

    // R2: an accepted route word lands in the addressed destination
    p_route_write_r2: assert property (@(posedge clk) disable iff (rst)
      (cmd.route_we && !bc_on && cmd.dst == 4'(i)) |=>
        map_q[i] == $past(cmd.src[SEL_W-1:0]));

    // R8: route words during broadcast leave the saved map alone
    p_bcast_hold_r8: assert property (@(posedge clk) disable iff (rst)
      (cmd.route_we && bc_on) |=> $stable(map_q[i]));

    // R6: broadcast on points every destination at the chosen source
    p_bcast_src_r6: assert property (@(posedge clk) disable iff (rst)
      (cmd.bcast_we && cmd.bc_flag) |=>
        src_sel[i*SEL_W +: SEL_W] == $past(cmd.src[SEL_W-1:0]));

    // R7: broadcast off shows the map held before
    p_restore_r7: assert property (@(posedge clk) disable iff (rst)
      (cmd.bcast_we && !cmd.bc_flag) |=>
        src_sel[i*SEL_W +: SEL_W] == $past(map_q[i]));
  end
endmodule

// File: rtl/xbar_lane_bank.sv
module xbar_lane_bank #(
  parameter int N_OUT = 16,
  localparam int N_BANK = N_OUT / 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [1:0]       bank,
  input  logic [3:0]       lane,
  output logic [N_OUT-1:0] bits_q
);
  for (genvar b = 0; b < N_BANK; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst)
        bits_q[4*b +: 4] <= '0;
      else if (we && bank == 2'(b))
        bits_q[4*b +: 4] <= lane;
    end

    // R3 (enables) and R4 (gains): selected bank takes the lane bits
    p_lane_write_r3: assert property (@(posedge clk) disable iff (rst)
      (we && bank == 2'(b)) |=> bits_q[4*b +: 4] == $past(lane));

    // R3/R4: the banks not selected keep their value
    p_lane_keep_r4: assert property (@(posedge clk) disable iff (rst)
      (we && bank != 2'(b)) |=> $stable(bits_q[4*b +: 4]));
  end
endmodule

// File: rtl/xbar_cfg_ctrl.sv
module xbar_cfg_ctrl
  import xbar_cfg_pkg::*;
#(
  parameter int N_IN  = 32,
  parameter int N_OUT = 16,
  localparam int SEL_W = $clog2(N_IN)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cmd_valid,
  output logic                   cmd_ready,
  input  logic [15:0]            cmd_word,
  output logic [N_OUT*SEL_W-1:0] src_sel,
  output logic [N_OUT-1:0]       drive_en,
  output logic [N_OUT-1:0]       gain_x2,
  output logic                   clamp_en,
  output logic                   standby
);
  cmd_t             cmd;
  logic [N_OUT-1:0] en_bits;
  logic             glob_q;
  logic             pwr_q;
  logic             clamp_q;

  assign cmd_ready = 1'b1;

  xbar_cmd_decode u_dec (
    .valid (cmd_valid),
    .word  (cmd_word),
    .cmd   (cmd)
  );

  xbar_route_map #(.N_IN(N_IN), .N_OUT(N_OUT)) u_map (
    .clk     (clk),
    .rst     (rst),
    .cmd     (cmd),
    .src_sel (src_sel)
  );

  xbar_lane_bank #(.N_OUT(N_OUT)) u_en (
    .clk    (clk),
    .rst    (rst),
    .we     (cmd.en_we),
    .bank   (cmd.bank),
    .lane   (cmd.lane),
    .bits_q (en_bits)
  );

  xbar_lane_bank #(.N_OUT(N_OUT)) u_gain (
    .clk    (clk),
    .rst    (rst),
    .we     (cmd.gain_we),
    .bank   (cmd.bank),
    .lane   (cmd.lane),
    .bits_q (gain_x2)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      clamp_q <= 1'b0;
      glob_q  <= 1'b0;
      pwr_q   <= 1'b0;
    end else if (cmd.ctrl_we) begin
      clamp_q <= cmd.ctrl[0];
      glob_q  <= cmd.ctrl[1];
      pwr_q   <= cmd.ctrl[2];
    end
  end

  assign drive_en = en_bits & {N_OUT{glob_q & pwr_q}};
  assign clamp_en = clamp_q;
  assign standby  = ~pwr_q;

  // R1: reset leaves everything off and in standby
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (standby && drive_en == '0 && gain_x2 == '0 && !clamp_en));

  // R5: a control word without both global enable and power stops all drive
  p_gate_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_word[15:13] == OPC_CTRL && !(cmd_word[1] && cmd_word[2]))
      |=> drive_en == '0);

  // R10: unused opcodes change nothing
  p_reserved_r10: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && (cmd_word[15:13] == 3'b100 || cmd_word[15:13] == 3'b101 ||
                   cmd_word[15:13] == 3'b110))
      |=> ($stable(src_sel) && $stable(drive_en) && $stable(gain_x2) &&
           $stable(clamp_en) && $stable(standby)));

  // R11: idle cycles change nothing
  p_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> ($stable(src_sel) && $stable(drive_en) && $stable(gain_x2) &&
                    $stable(clamp_en) && $stable(standby)));
endmodule

// File: tb/xbar_cfg_ctrl_test.sv
`timescale 1ns/1ps
module xbar_cfg_ctrl_test;
  localparam int NO = 16;
  localparam int SW = 5;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           cmd_valid = 1'b0;
  logic           cmd_ready;
  logic [15:0]    cmd_word = '0;
  logic [NO*SW-1:0] src_sel;
  logic [NO-1:0]  drive_en;
  logic [NO-1:0]  gain_x2;
  logic           clamp_en;
  logic           standby;

  int vectors = 0;
  int misses  = 0;

  // reference model state
  logic [4:0]    m_map [NO];
  logic          m_bc;
  logic [4:0]    m_bsrc;
  logic [NO-1:0] m_en, m_gain;
  logic          m_clamp, m_glob, m_pwr;

  always #4 clk = ~clk;

  xbar_cfg_ctrl uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_word(cmd_word), .src_sel(src_sel), .drive_en(drive_en),
    .gain_x2(gain_x2), .clamp_en(clamp_en), .standby(standby)
  );

  task automatic model_reset();
    for (int i = 0; i < NO; i++) m_map[i] = '0;
    m_bc = 0; m_bsrc = '0; m_en = '0; m_gain = '0;
    m_clamp = 0; m_glob = 0; m_pwr = 0;
  endtask

  task automatic model_apply(input logic [15:0] w);
    int b;
    b = int'(w[9:8]);
    case (w[15:13])
      3'b000: if (!m_bc) m_map[w[3:0]] = w[12:8];
      3'b001: for (int k = 0; k < 4; k++) m_en[4*b+k] = w[2*k];
      3'b010: for (int k = 0; k < 4; k++) m_gain[4*b+k] = w[2*k];
      3'b011: begin m_bc = w[0]; m_bsrc = w[12:8]; end
      3'b111: begin m_clamp = w[0]; m_glob = w[1]; m_pwr = w[2]; end
      default: ;
    endcase
  endtask

  task automatic chk(input string tag, input string what,
                     input logic [NO*SW-1:0] act, input logic [NO*SW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    logic [NO*SW-1:0] es;
    for (int i = 0; i < NO; i++) es[i*SW +: SW] = m_bc ? m_bsrc : m_map[i];
    chk(tag, "src_sel", src_sel, es);
    chk(tag, "drive_en", {64'd0, drive_en}, {64'd0, m_en & {NO{m_glob & m_pwr}}});
    chk(tag, "gain_x2", {64'd0, gain_x2}, {64'd0, m_gain});
    chk(tag, "clamp/standby/ready", {77'd0, clamp_en, standby, cmd_ready},
        {77'd0, m_clamp, ~m_pwr, 1'b1});
  endtask

  // drive at negedge, accepted at posedge, checked at next negedge
  task automatic send(input logic [15:0] w, input string tag);
    cmd_word  = w;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    model_apply(w);
    check_all(tag);
  endtask

  function automatic string tag_of(input logic [15:0] w);
    case (w[15:13])
      3'b000:  return "R2";
      3'b001:  return "R3";
      3'b010:  return "R4";
      3'b011:  return "R6";
      3'b111:  return "R9";
      default: return "R10";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    misses++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    model_reset();
    repeat (3) @(negedge clk);
    check_all("R1");
    rst = 1'b0;
    @(negedge clk);
    check_all("R1");

    // R9 / R5: every control value, with all individual enables on
    for (int b = 0; b < 4; b++) send({3'b001, 3'b0, 2'(b), 8'h55}, "R3");
    for (int c = 0; c < 8; c++) send({3'b111, 10'd0, 3'(c)}, "R5");
    send({3'b111, 13'd6}, "R9");

    // R3 / R4: every lane pattern in every bank
    for (int b = 0; b < 4; b++)
      for (int p = 0; p < 16; p++) begin
        send({3'b001, 3'b0, 2'(b), 1'b0, p[3], 1'b0, p[2], 1'b0, p[1], 1'b0, p[0]}, "R3");
        send({3'b010, 3'b0, 2'(b), 1'b0, p[0], 1'b0, p[3], 1'b0, p[1], 1'b0, p[2]}, "R4");
      end

    // R2: every source into every destination
    for (int s = 0; s < 32; s++)
      for (int d = 0; d < NO; d++) send({3'b000, 5'(s), 4'd0, 4'(d)}, "R2");
    for (int d = 0; d < NO; d++) send({3'b000, 5'(3*d+1), 4'd0, 4'(d)}, "R2");

    // R6 / R8 / R7: broadcast sweep, routes dropped, then restore
    for (int s = 0; s < 32; s++) send({3'b011, 5'(s), 8'd1}, "R6");
    for (int d = 0; d < NO; d++) send({3'b000, 5'(31-d), 4'd0, 4'(d)}, "R8");
    send({3'b011, 5'd9, 8'd0}, "R7");

    // R10: unused opcodes
    for (int o = 4; o < 7; o++) send({3'(o), 13'h1FFF}, "R10");
    // R11: idle cycles with live-looking words
    for (int k = 0; k < 8; k++) begin
      cmd_word = {3'b111, 13'(k)};
      @(negedge clk);
      check_all("R11");
    end

    // mixed stream
    lfsr = 16'hACE1;
    for (int n = 0; n < 3000; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      send(lfsr, tag_of(lfsr));
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule